// File: doc/BRIEF.md
# Oscillator-Dependent Reset Hold-Off Timer

This block keeps a processor core in reset for a fixed number of ticks after a reset event has ended. The hold-off gives the supply time to settle and the selected clock source time to start. The block runs on its own free-running timer clock, which is separate from the core clock. A single-cycle event pulse starts it. With the pulse come a flag that marks the event as a power-on and an encoded oscillator mode. From the flag and the mode the block picks one of three hold-off lengths and latches that choice.

Resonator and crystal modes always get the long hold-off. For externally clocked, internal-oscillator and RC modes, a power-on gets a medium hold-off and any other reset gets a very short one. Counting begins only once the external reset pin reads high through a synchronizer. If the pin goes low again, the core goes back into reset and counting later starts over. A new event that arrives while counting is in progress restarts the count from zero with the class of the new event.

Top module: `drt_hold_timer`

## Requirements
- R1: While `rst_ni` is low, and after it is released until some event's hold-off has fully counted out, `core_rst_o` is 1. Releasing `rst_ni` alone never lowers it.
- R2: Mode codes 0, 1 and 2 (the three crystal or resonator types) select the long hold-off of `LONG_TICKS`, whether `trig_por_i` is 1 or 0.
- R3: Mode codes 3, 4 and 5 (external clock, internal oscillator, RC) with `trig_por_i`=1 select the medium hold-off of `MID_TICKS`.
- R4: Mode codes 3, 4 and 5 with `trig_por_i`=0 select the short hold-off of `SHORT_TICKS`.
- R5: The unassigned mode codes 6 and 7 fall back to the long hold-off of `LONG_TICKS`.
- R6: If the pin has been high long enough to be synchronized, and the edge that samples `trig_i`=1 is edge 0, then `core_rst_o` first reads 0 after edge D+1, where D is the selected tick count. It reads 1 after every edge from 0 through D.
- R7: While the synchronized pin is low, `core_rst_o` stays 1. When the pin rises, count the first edge that samples it high as edge 1. `core_rst_o` then first reads 0 after edge `SYNC_STAGES`+D+1.
- R8: A pin low pulse during counting, or after the hold-off has ended, puts the core back in reset. The full hold-off D is then counted again once the pin is high.
- R9: A `trig_i` pulse that arrives during counting restarts the count from zero. The restarted count uses the class of the new event.
- R10: `osc_mode_i` and `trig_por_i` are sampled only on the edge where `trig_i` is 1. Changing them afterwards does not change the running hold-off.
- R11: Once `core_rst_o` has fallen, it stays 0 for as long as no event arrives and the pin stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running timer clock; one tick per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the timer itself |
| trig_i | input | 1 | One-cycle pulse marking the end of a reset event |
| trig_por_i | input | 1 | 1 when the event is a power-on, sampled with `trig_i` |
| osc_mode_i | input | 3 | Oscillator mode code (0..7), sampled with `trig_i` |
| rst_pin_i | input | 1 | Level of the external reset pin, asynchronous, active low |
| core_rst_o | output | 1 | Reset to the core, 1 = core held in reset |

## Verification
The bench builds the block with a long hold-off of 12 ticks, a medium one of 6, a short one of 2 and a two-stage pin synchronizer. With counts this small, every code and flag pair can be measured edge by edge from pulse to release, and the three classes stay distinguishable from one another. Restarts in mid-count, pin drops at several points and late changes to the mode inputs then fit into runs of a few dozen cycles. The same small values keep the off-by-one boundaries of R6 and R7 easy to observe.

// File: rtl/drt_pkg.sv
package drt_pkg;

   localparam int unsigned MODE_W = 3;

   // Oscillator mode codes; the delay class depends on these values.
   localparam logic [MODE_W-1:0] MODE_XTAL_LP  = 3'd0;
   localparam logic [MODE_W-1:0] MODE_XTAL_STD = 3'd1;
   localparam logic [MODE_W-1:0] MODE_XTAL_HS  = 3'd2;
   localparam logic [MODE_W-1:0] MODE_EXT_CLK  = 3'd3;
   localparam logic [MODE_W-1:0] MODE_INT_OSC  = 3'd4;
   localparam logic [MODE_W-1:0] MODE_EXT_RC   = 3'd5;

   typedef enum logic [1:0] {
      DLY_LONG  = 2'd0,
      DLY_MID   = 2'd1,
      DLY_SHORT = 2'd2
   } dly_class_e;

   typedef enum logic [1:0] {
      ST_HOLD     = 2'd0,
      ST_WAIT_PIN = 2'd1,
      ST_COUNT    = 2'd2,
      ST_RUN      = 2'd3
   } hold_state_e;

   // Fast-start modes get a power-on / later split; everything else is long.
   function automatic dly_class_e classify(input logic [MODE_W-1:0] mode,
                                           input logic              por);
      dly_class_e cls;
      case (mode)
         MODE_EXT_CLK, MODE_INT_OSC, MODE_EXT_RC:
            cls = por ? DLY_MID : DLY_SHORT;
         default:
            cls = DLY_LONG;
      endcase
      return cls;
   endfunction

endpackage

// File: rtl/drt_pin_sync.sv
module drt_pin_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_i,
   output logic pin_o
);

   if (STAGES == 0) begin : g_bypass
      assign pin_o = pin_i;
   end else begin : g_chain
      logic [STAGES-1:0] sync_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) sync_q[0] <= 1'b0;
         else         sync_q[0] <= pin_i;
      end

      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sync_q[i] <= 1'b0;
            else         sync_q[i] <= sync_q[i-1];
         end
      end

      assign pin_o = sync_q[STAGES-1];
   end

endmodule

// File: rtl/drt_class_latch.sv
module drt_class_latch
   import drt_pkg::*;
#(
   parameter int unsigned LONG_TICKS  = 1800,
   parameter int unsigned MID_TICKS   = 113,
   parameter int unsigned SHORT_TICKS = 1,
   parameter bit          STORE_LIMIT = 1'b0,
   parameter int unsigned CNT_W       = $clog2(LONG_TICKS + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              trig_i,
   input  logic              por_i,
   input  logic [MODE_W-1:0] mode_i,
   output logic [CNT_W-1:0]  limit_o
);

   localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(LONG_TICKS);
   localparam logic [CNT_W-1:0] LIM_MID   = CNT_W'(MID_TICKS);
   localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(SHORT_TICKS);

   function automatic logic [CNT_W-1:0] class_limit(input dly_class_e cls);
      logic [CNT_W-1:0] lim;
      case (cls)
         DLY_MID:   lim = LIM_MID;
         DLY_SHORT: lim = LIM_SHORT;
         default:   lim = LIM_LONG;
      endcase
      return lim;
   endfunction

   dly_class_e new_cls;
   assign new_cls = classify(mode_i, por_i);

   if (STORE_LIMIT) begin : g_store_limit
      // Wide register, no decode between it and the counter compare.
      logic [CNT_W-1:0] lim_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     lim_q <= LIM_LONG;
         else if (trig_i) lim_q <= class_limit(new_cls);
      end
      assign limit_o = lim_q;
   end else begin : g_store_class
      // Two-bit register, limit decoded behind it.
      dly_class_e cls_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     cls_q <= DLY_LONG;
         else if (trig_i) cls_q <= new_cls;
      end
      assign limit_o = class_limit(cls_q);
   end

   // R10: the captured hold-off only changes on a trigger edge
   a_r10_limit_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !trig_i |=> $stable(limit_o));

   // R2, R5: a long-class capture yields the long limit
   a_r2_long_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig_i && new_cls == DLY_LONG) |=> limit_o == LIM_LONG);

endmodule

// File: rtl/drt_tick_counter.sv
module drt_tick_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             step_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             done_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             last_tick;

   assign last_tick = (cnt_q == limit_i - CNT_W'(1));
   assign done_o    = step_i && last_tick;

   // Any cycle without a step clears the count, so each run starts at zero.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  cnt_q <= '0;
      else if (step_i && !last_tick) cnt_q <= cnt_q + CNT_W'(1);
      else                          cnt_q <= '0;
   end

   // R6: while stepping the count never reaches the limit
   a_r6_cnt_below_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_i |-> cnt_q < limit_i);

   // R9: a pause in stepping leaves the counter at zero
   a_r9_cnt_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !step_i |=> cnt_q == '0);

endmodule

// File: rtl/drt_hold_timer.sv
module drt_hold_timer
   import drt_pkg::*;
#(
   parameter int unsigned LONG_TICKS  = 1800,
   parameter int unsigned MID_TICKS   = 113,
   parameter int unsigned SHORT_TICKS = 1,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          STORE_LIMIT = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              trig_i,
   input  logic              trig_por_i,
   input  logic [MODE_W-1:0] osc_mode_i,
   input  logic              rst_pin_i,
   output logic              core_rst_o
);

   localparam int unsigned CNT_W = $clog2(LONG_TICKS + 1);

   if (SHORT_TICKS < 1) begin : g_chk_short
      $error("SHORT_TICKS must be at least 1");
   end
   if (MID_TICKS < SHORT_TICKS || LONG_TICKS < MID_TICKS) begin : g_chk_order
      $error("tick counts must satisfy LONG >= MID >= SHORT");
   end
   if (SYNC_STAGES > 4) begin : g_chk_sync
      $error("SYNC_STAGES above 4 is not supported");
   end

   logic             pin_ok;
   logic [CNT_W-1:0] limit;
   logic             cnt_step;
   logic             cnt_done;
   hold_state_e      state_q, state_d;

   drt_pin_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (rst_pin_i),
      .pin_o  (pin_ok)
   );

   drt_class_latch #(
      .LONG_TICKS  (LONG_TICKS),
      .MID_TICKS   (MID_TICKS),
      .SHORT_TICKS (SHORT_TICKS),
      .STORE_LIMIT (STORE_LIMIT),
      .CNT_W       (CNT_W)
   ) u_class (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .trig_i  (trig_i),
      .por_i   (trig_por_i),
      .mode_i  (osc_mode_i),
      .limit_o (limit)
   );

   // Count only in COUNT, with the pin still high and no new event.
   assign cnt_step = (state_q == ST_COUNT) && pin_ok && !trig_i;

   drt_tick_counter #(.CNT_W(CNT_W)) u_counter (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .step_i  (cnt_step),
      .limit_i (limit),
      .done_o  (cnt_done)
   );

   always_comb begin
      state_d = state_q;
      if (trig_i) begin
         state_d = ST_WAIT_PIN;
      end else begin
         case (state_q)
            ST_HOLD:     state_d = ST_HOLD;
            ST_WAIT_PIN: if (pin_ok) state_d = ST_COUNT;
            ST_COUNT: begin
               if (!pin_ok)      state_d = ST_WAIT_PIN;
               else if (cnt_done) state_d = ST_RUN;
            end
            ST_RUN:      if (!pin_ok) state_d = ST_WAIT_PIN;
            default:     state_d = ST_HOLD;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_HOLD;
      else         state_q <= state_d;
   end

   assign core_rst_o = (state_q != ST_RUN);

   // R9: every event puts the core into reset on the next tick
   a_r9_trig_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_i |=> core_rst_o);

   // R7, R8: a low synchronized pin keeps or puts the core in reset
   a_r8_pin_low_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pin_ok |=> core_rst_o);

   // R6: release only comes from the counter finishing
   a_r6_release_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(core_rst_o) |-> $past(cnt_done));

   // R11: released core stays released while quiet
   a_r11_run_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!core_rst_o && !trig_i && pin_ok) |=> !core_rst_o);

   // R1: without an event the timer never leaves its hold state
   a_r1_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_HOLD && !trig_i) |=> state_q == ST_HOLD);

endmodule

// File: tb/drt_hold_timer_tb.sv
module drt_hold_timer_tb;

   localparam int unsigned L_T = 12;
   localparam int unsigned M_T = 6;
   localparam int unsigned S_T = 2;
   localparam int unsigned SYN = 2;
   localparam int NVEC = 16;

   // mode, por, expected hold-off ticks
   localparam int VMODE [NVEC] = '{0,0,1,1,2,2,3,3,4,4,5,5,6,6,7,7};
   localparam int VPOR  [NVEC] = '{0,1,0,1,0,1,0,1,0,1,0,1,0,1,0,1};
   localparam int VTICK [NVEC] = '{L_T,L_T,L_T,L_T,L_T,L_T,S_T,M_T,
                                   S_T,M_T,S_T,M_T,L_T,L_T,L_T,L_T};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       trig = 1'b0;
   logic       por = 1'b0;
   logic [2:0] mode = 3'd0;
   logic       pin = 1'b0;
   logic       core_rst;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   drt_hold_timer #(
      .LONG_TICKS(L_T), .MID_TICKS(M_T), .SHORT_TICKS(S_T),
      .SYNC_STAGES(SYN), .STORE_LIMIT(1'b0)
   ) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .trig_por_i(por),
      .osc_mode_i(mode), .rst_pin_i(pin), .core_rst_o(core_rst)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic edges(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   // Pulse trig across one edge (edge 0); returns at the negedge after it.
   task automatic fire(input int m, input int p);
      mode = 3'(m);
      por  = p[0];
      trig = 1'b1;
      @(posedge clk);
      @(negedge clk);
      trig = 1'b0;
   endtask

   // Counts edges until core_rst reads 0 (0 if it never falls within lim).
   task automatic measure(input int lim, output int n);
      n = 0;
      for (int i = 1; i <= lim; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (!core_rst) begin
            n = i;
            break;
         end
      end
   endtask

   initial begin : wdog
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      int n;
      @(negedge clk);
      edges(3);
      check("R1 core held in reset", core_rst, 1);
      pin = 1'b1;
      edges(2);
      rst_n = 1'b1;
      edges(20);
      check("R1 no event, still held after release", core_rst, 1);

      // Vector table: every mode code with both reset kinds
      for (int v = 0; v < NVEC; v++) begin
         fire(VMODE[v], VPOR[v]);
         check("R6 held right after event", core_rst, 1);
         measure(40, n);
         if (VMODE[v] <= 2)
            check($sformatf("R2 mode %0d por %0d", VMODE[v], VPOR[v]), n, VTICK[v] + 1);
         else if (VMODE[v] >= 6)
            check($sformatf("R5 mode %0d por %0d", VMODE[v], VPOR[v]), n, VTICK[v] + 1);
         else if (VPOR[v] == 1)
            check($sformatf("R3 mode %0d", VMODE[v]), n, VTICK[v] + 1);
         else
            check($sformatf("R4 mode %0d", VMODE[v]), n, VTICK[v] + 1);
      end

      // R11: stays released while quiet
      edges(15);
      check("R11 released core stays released", core_rst, 0);

      // R7: event with pin low, then release the pin
      pin = 1'b0;
      fire(4, 0);
      edges(10);
      check("R7 held while pin low", core_rst, 1);
      pin = 1'b1;
      measure(40, n);
      check("R7 release after pin rise", n, SYN + S_T + 1);

      // R8: pin drop mid-count, long class
      fire(1, 0);
      edges(4);
      pin = 1'b0;
      edges(12);
      check("R8 held after mid-count pin drop", core_rst, 1);
      pin = 1'b1;
      measure(40, n);
      check("R8 full recount after pin returns", n, SYN + L_T + 1);

      // R8: pin drop after release
      pin = 1'b0;
      edges(SYN + 1);
      check("R8 pin drop re-asserts reset", core_rst, 1);
      pin = 1'b1;
      measure(40, n);
      check("R8 recount after drop in run", n, SYN + L_T + 1);

      // R9: restart a long count with a short-class event
      fire(0, 1);
      edges(5);
      check("R9 still counting long", core_rst, 1);
      fire(5, 0);
      measure(40, n);
      check("R9 restart uses new short class", n, S_T + 1);

      // R9: restart a medium count with a long-class event
      fire(3, 1);
      edges(3);
      fire(2, 0);
      measure(40, n);
      check("R9 restart uses new long class", n, L_T + 1);

      // R10: inputs changed after the event do not affect it
      fire(3, 1);
      mode = 3'd0;
      por  = 1'b0;
      measure(40, n);
      check("R10 medium kept despite input change", n, M_T + 1);
      fire(4, 0);
      mode = 3'd7;
      por  = 1'b1;
      measure(40, n);
      check("R10 short kept despite input change", n, S_T + 1);

      // R1: reset during run forces hold again
      rst_n = 1'b0;
      edges(1);
      check("R1 reset re-asserts core reset", core_rst, 1);
      rst_n = 1'b1;
      edges(20);
      check("R1 no event after reset, still held", core_rst, 1);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule